// File: doc/BRIEF.md
# Power-Line PHY Frame Bit Sequencer

This block produces the serial bit stream of one power-line PHY frame. The training sequence is not part of this stream. A start pulse latches a transmit mode number and a payload length. The block first checks both values. If they are legal, it emits the following bits in order:

- a fixed 11-bit synchronisation word;
- a 12-bit header, made of the mode number, one reserved zero bit and six zero tail bits;
- the payload bits, taken from an upstream valid/ready stream;
- six zero data tail bits, but only when the mode uses a convolutional code.

Each emitted bit carries a section tag, a code-mode tag and a last-of-section flag. The encoder downstream uses these tags to pick its code. The header is always tagged with mode 0, whatever mode the payload uses. The payload is tagged with the latched mode.

Output uses valid/ready handshaking. When the consumer stalls, the current bit is held and nothing is lost. Payload bits pass straight through from the upstream stream, so upstream sees ready only while the payload section is active and the consumer is ready. A one-cycle done pulse follows the final accepted bit. A start request with an illegal mode or length is refused: an error flag rises for one cycle and no bits are emitted.

Top module: `phy_bitseq`

## Requirements
- R1: After reset, out_valid_o, pl_ready_o, start_err_o and done_o are all 0.
- R2: A frame begins with 11 bits tagged section 0 (sync): 1,1,1,0,0,0,1,0,0,1,0. This is the value 0x247 sent least significant bit first.
- R3: Next come 12 bits tagged section 1 (header):
  - the 5-bit mode number, least significant bit first;
  - one reserved 0 bit;
  - six 0 bits.
  During the sync and header sections, out_mode_o is 0.
- R4: Next, the payload bits are forwarded in arrival order, exactly len_i of them. They are tagged section 2 (data), and out_mode_o equals the latched mode.
- R5: For modes 0 to 15, six 0 bits tagged section 2 follow the payload. Modes 16 to 20 emit no tail bits.
- R6: A start with a mode number of 21 to 31 pulses start_err_o for one cycle, in the cycle after the start, and emits no bits.
- R7: A start with a length below 96 or above 2152 is refused in the same way as in R6.
- R8: out_last_o is 1 on exactly these bits, and on no others:
  - the final sync bit;
  - the final header bit;
  - the final bit of the data section (the last tail bit, or the last payload bit when the mode has no tail).
- R9: While out_valid_o is 1 and out_ready_i is 0, the offered bit and its tags are held. pl_ready_o is 1 only during the data section and only while out_ready_i is 1.
- R10: done_o is 1 for exactly one cycle, the cycle after the final bit is accepted.
- R11: A start pulse while a frame is in progress is ignored, and the stream in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start request |
| mode_i | input | 5 | Transmit mode number, latched at start |
| len_i | input | 12 | Payload length in bits, latched at start |
| start_err_o | output | 1 | One-cycle pulse when a start request is refused |
| pl_valid_i | input | 1 | Payload bit valid |
| pl_bit_i | input | 1 | Payload bit |
| pl_ready_o | output | 1 | Payload bit accepted this cycle when valid |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Consumer ready |
| out_bit_o | output | 1 | Output bit |
| out_sec_o | output | 2 | Section tag: 0 sync, 1 header, 2 data |
| out_mode_o | output | 5 | Code-mode tag for the bit |
| out_last_o | output | 1 | Final bit of its section |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
Some properties are checked on every cycle:
- a stalled bit in the sync or header section is held steady;
- the mode tag is zero in front of the data section;
- payload ready follows consumer ready;
- an error pulse coincides with silence on the output;
- done is a single cycle and follows an accepted final data bit.

Other properties only the bench scenarios can show, because they need a model of the whole frame:
- the exact bit values of the sync word and header;
- whether tail bits are present for each mode class;
- payload order and count under random stalls from both sides;
- the refusal of each illegal mode and length boundary;
- immunity to a start pulse that arrives mid-frame.

// File: rtl/phy_bitseq_pkg.sv
// Shared types for the PHY frame bit sequencer.
// Assumes: section codes are decoded downstream, so their values are fixed.
package phy_bitseq_pkg;

    typedef enum logic [1:0] {
        SEC_SYNC = 2'd0,
        SEC_HDR  = 2'd1,
        SEC_DATA = 2'd2
    } sec_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HDR,
        ST_PAY,
        ST_TAIL,
        ST_DONE
    } st_e;

endpackage

// File: rtl/phy_bitseq_validate.sv
// Start-request checker: decides whether a mode/length pair is legal and
// whether the mode needs data tail bits.
// Assumes: inputs are only meaningful together with a start pulse.
module phy_bitseq_validate #(
    parameter int MODE_W        = 5,
    parameter int LEN_W         = 12,
    parameter int MAX_MODE      = 20,
    parameter int CONV_MAX_MODE = 15,
    parameter int MIN_LEN       = 96,
    parameter int MAX_LEN       = 2152
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ok_o,
    output logic              tail_o
);

    // Range checks on mode and payload length.
    always_comb begin
        ok_o = (mode_i <= MODE_W'(MAX_MODE)) &&
               (len_i  >= LEN_W'(MIN_LEN))   &&
               (len_i  <= LEN_W'(MAX_LEN));
        tail_o = (mode_i <= MODE_W'(CONV_MAX_MODE));
    end

endmodule

// File: rtl/phy_bitseq_fsm.sv
// Section sequencer: walks sync, header, payload, optional tail and done.
// A single counter indexes the bit inside the current section.
// Assumes: fire_i is 1 only when the current bit is handed over.
module phy_bitseq_fsm
    import phy_bitseq_pkg::*;
#(
    parameter int MODE_W    = 5,
    parameter int LEN_W     = 12,
    parameter int SYNC_W    = 11,
    parameter int TAIL_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ok_i,
    input  logic              tail_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              fire_i,
    output st_e               st_o,
    output logic [LEN_W-1:0]  cnt_o,
    output logic [MODE_W-1:0] mode_q_o,
    output logic              last_o,
    output logic              err_o,
    output logic              done_o
);

    localparam int HDR_BITS = MODE_W + 1 + TAIL_BITS;

    st_e              st;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic             tail_q;

    // Final bit of the current section.
    always_comb begin
        unique case (st)
            ST_SYNC: last_o = (cnt == LEN_W'(SYNC_W - 1));
            ST_HDR:  last_o = (cnt == LEN_W'(HDR_BITS - 1));
            ST_PAY:  last_o = (cnt == len_q - LEN_W'(1)) && !tail_q;
            ST_TAIL: last_o = (cnt == LEN_W'(TAIL_BITS - 1));
            default: last_o = 1'b0;
        endcase
    end

    // State, counter and start latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            tail_q   <= 1'b0;
            mode_q_o <= '0;
            err_o    <= 1'b0;
        end else begin
            err_o <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        if (ok_i) begin
                            st       <= ST_SYNC;
                            cnt      <= '0;
                            len_q    <= len_i;
                            tail_q   <= tail_i;
                            mode_q_o <= mode_i;
                        end else begin
                            err_o <= 1'b1;
                        end
                    end
                end
                ST_SYNC, ST_HDR, ST_TAIL: begin
                    if (fire_i) begin
                        if (last_o) begin
                            cnt <= '0;
                            st  <= (st == ST_SYNC) ? ST_HDR :
                                   (st == ST_HDR)  ? ST_PAY : ST_DONE;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (fire_i) begin
                        if (cnt == len_q - LEN_W'(1)) begin
                            cnt <= '0;
                            st  <= tail_q ? ST_TAIL : ST_DONE;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign st_o   = st;
    assign cnt_o  = cnt;
    assign done_o = (st == ST_DONE);

endmodule

// File: rtl/phy_bitseq_mux.sv
// Output selector: forms the bit, tags and handshake from the sequencer state.
// Assumes: the payload stream holds its bit while valid and not ready.
module phy_bitseq_mux
    import phy_bitseq_pkg::*;
#(
    parameter int                MODE_W    = 5,
    parameter int                LEN_W     = 12,
    parameter int                SYNC_W    = 11,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 11'h247
) (
    input  st_e               st_i,
    input  logic [LEN_W-1:0]  cnt_i,
    input  logic [MODE_W-1:0] mode_q_i,
    input  logic              last_i,
    input  logic              pl_valid_i,
    input  logic              pl_bit_i,
    input  logic              out_ready_i,
    output logic              pl_ready_o,
    output logic              out_valid_o,
    output logic              out_bit_o,
    output sec_e              out_sec_o,
    output logic [MODE_W-1:0] out_mode_o,
    output logic              out_last_o
);

    logic sync_bit;
    logic mode_bit;

    // Bit selected by counter position; out-of-range shifts give 0.
    always_comb begin
        sync_bit = |(SYNC_WORD & (SYNC_W'(1) << cnt_i));
        mode_bit = |(mode_q_i & (MODE_W'(1) << cnt_i));
    end

    // Per-state bit value, tags and handshake.
    always_comb begin
        out_valid_o = 1'b0;
        out_bit_o   = 1'b0;
        out_sec_o   = SEC_SYNC;
        out_mode_o  = '0;
        unique case (st_i)
            ST_SYNC: begin
                out_valid_o = 1'b1;
                out_bit_o   = sync_bit;
            end
            ST_HDR: begin
                out_valid_o = 1'b1;
                out_bit_o   = mode_bit;
                out_sec_o   = SEC_HDR;
            end
            ST_PAY: begin
                out_valid_o = pl_valid_i;
                out_bit_o   = pl_bit_i;
                out_sec_o   = SEC_DATA;
                out_mode_o  = mode_q_i;
            end
            ST_TAIL: begin
                out_valid_o = 1'b1;
                out_sec_o   = SEC_DATA;
                out_mode_o  = mode_q_i;
            end
            default: ;
        endcase
        out_last_o = last_i && out_valid_o;
        pl_ready_o = (st_i == ST_PAY) && out_ready_i;
    end

endmodule

// File: rtl/phy_bitseq.sv
// PHY frame bit sequencer top: validates a start request, then emits sync,
// header, payload and optional tail bits with section and mode tags.
// Assumes: the consumer and the payload source follow valid/ready rules.
module phy_bitseq
    import phy_bitseq_pkg::*;
#(
    parameter int                MODE_W        = 5,
    parameter int                LEN_W         = 12,
    parameter int                MAX_MODE      = 20,
    parameter int                CONV_MAX_MODE = 15,
    parameter int                MIN_LEN       = 96,
    parameter int                MAX_LEN       = 2152,
    parameter int                SYNC_W        = 11,
    parameter logic [SYNC_W-1:0] SYNC_WORD     = 11'h247,
    parameter int                TAIL_BITS     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              start_err_o,
    input  logic              pl_valid_i,
    input  logic              pl_bit_i,
    output logic              pl_ready_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic              out_bit_o,
    output logic [1:0]        out_sec_o,
    output logic [MODE_W-1:0] out_mode_o,
    output logic              out_last_o,
    output logic              done_o
);

    logic              ok;
    logic              tail;
    st_e               st;
    logic [LEN_W-1:0]  cnt;
    logic [MODE_W-1:0] mode_q;
    logic              last;
    sec_e              sec;

    phy_bitseq_validate #(
        .MODE_W(MODE_W), .LEN_W(LEN_W), .MAX_MODE(MAX_MODE),
        .CONV_MAX_MODE(CONV_MAX_MODE), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) u_validate (
        .mode_i(mode_i), .len_i(len_i), .ok_o(ok), .tail_o(tail)
    );

    phy_bitseq_fsm #(
        .MODE_W(MODE_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W), .TAIL_BITS(TAIL_BITS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ok_i(ok), .tail_i(tail),
        .mode_i(mode_i), .len_i(len_i), .fire_i(out_valid_o && out_ready_i),
        .st_o(st), .cnt_o(cnt), .mode_q_o(mode_q), .last_o(last),
        .err_o(start_err_o), .done_o(done_o)
    );

    phy_bitseq_mux #(
        .MODE_W(MODE_W), .LEN_W(LEN_W), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)
    ) u_mux (
        .st_i(st), .cnt_i(cnt), .mode_q_i(mode_q), .last_i(last),
        .pl_valid_i(pl_valid_i), .pl_bit_i(pl_bit_i), .out_ready_i(out_ready_i),
        .pl_ready_o(pl_ready_o), .out_valid_o(out_valid_o), .out_bit_o(out_bit_o),
        .out_sec_o(sec), .out_mode_o(out_mode_o), .out_last_o(out_last_o)
    );

    assign out_sec_o = sec;

endmodule

// File: rtl/phy_bitseq_chk.sv
// Checker for the sequencer's port-level rules, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module phy_bitseq_chk #(
    parameter int MODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              start_err_o,
    input logic              pl_ready_o,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic              out_bit_o,
    input logic [1:0]        out_sec_o,
    input logic [MODE_W-1:0] out_mode_o,
    input logic              out_last_o,
    input logic              done_o
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && out_sec_o != 2'd2) |=> (out_valid_o && $stable(out_bit_o) && $stable(out_sec_o))); // R9

    AST_PL_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready_o |-> (out_ready_i && out_sec_o == 2'd2)); // R9

    AST_PREFIX_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_sec_o != 2'd2) |-> (out_mode_o == '0)); // R3

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> !out_valid_o); // R6

    AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> $past(start_i)); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(out_valid_o && out_ready_i && out_last_o && out_sec_o == 2'd2)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

endmodule

bind phy_bitseq phy_bitseq_chk #(.MODE_W(MODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_err_o(start_err_o),
    .pl_ready_o(pl_ready_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_bit_o(out_bit_o), .out_sec_o(out_sec_o), .out_mode_o(out_mode_o),
    .out_last_o(out_last_o), .done_o(done_o)
);

// File: tb/phy_bitseq_bench.sv
// Scoreboard bench: the frame task queues the expected bits, a monitor pops
// and compares every accepted output bit.
module phy_bitseq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [4:0]  mode_i;
    logic [11:0] len_i;
    logic        start_err_o;
    logic        pl_valid_i;
    logic        pl_bit_i;
    logic        pl_ready_o;
    logic        out_valid_o;
    logic        out_ready_i;
    logic        out_bit_o;
    logic [1:0]  out_sec_o;
    logic [4:0]  out_mode_o;
    logic        out_last_o;
    logic        done_o;

    always #5 clk = ~clk;

    phy_bitseq u_phy_bitseq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .len_i(len_i),
        .start_err_o(start_err_o), .pl_valid_i(pl_valid_i), .pl_bit_i(pl_bit_i),
        .pl_ready_o(pl_ready_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_bit_o(out_bit_o), .out_sec_o(out_sec_o), .out_mode_o(out_mode_o),
        .out_last_o(out_last_o), .done_o(done_o)
    );

    typedef struct packed {
        logic       b;
        logic [1:0] sec;
        logic [4:0] mode;
        logic       last;
        logic       tl;
    } item_t;

    item_t       expq[$];
    logic        pay [0:2151];
    int          pidx = 0;
    bit          stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        exp_done = 1'b0;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stimulus: consumer ready, payload valid and payload bit.
    always @(negedge clk) begin
        lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready_i <= stall_en ? lfsr[3] : 1'b1;
        pl_valid_i  <= stall_en ? lfsr[7] : 1'b1;
        pl_bit_i    <= pay[(pidx < 2152) ? pidx : 0];
    end

    // Monitor: compare every accepted bit against the scoreboard.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (exp_done || done_o)
                check(done_o == exp_done, "R10 done pulse", int'(done_o), int'(exp_done));
            exp_done = 1'b0;
            if (out_valid_o && out_ready_i) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R11 unexpected output bit", 1, 0);
                end else begin
                    item_t it;
                    item_t got;
                    string tag;
                    it  = expq.pop_front();
                    got = '{b: out_bit_o, sec: out_sec_o, mode: out_mode_o,
                            last: out_last_o, tl: it.tl};
                    if (got.last != it.last)  tag = "R8 last flag";
                    else if (it.sec == 2'd0)  tag = "R2 sync bit";
                    else if (it.sec == 2'd1)  tag = "R3 header bit";
                    else if (it.tl)           tag = "R5 tail bit";
                    else                      tag = "R4 payload bit";
                    check(got == it, tag, int'(got), int'(it));
                    exp_done = it.last && (it.sec == 2'd2);
                end
            end
            if (pl_ready_o && pl_valid_i) pidx++;
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_frame(input int mode, input int len, input bit stl, input bit mid);
        int n;
        for (int i = 0; i < len; i++) pay[i] = logic'(((i * 37) >> 2) ^ (i / 5) ^ mode);
        for (int i = 0; i < 11; i++)
            expq.push_back('{b: logic'((11'h247 >> i) & 1), sec: 2'd0, mode: 5'd0,
                             last: (i == 10), tl: 1'b0});
        for (int i = 0; i < 12; i++)
            expq.push_back('{b: (i < 5) ? logic'((mode >> i) & 1) : 1'b0, sec: 2'd1,
                             mode: 5'd0, last: (i == 11), tl: 1'b0});
        for (int i = 0; i < len; i++)
            expq.push_back('{b: pay[i], sec: 2'd2, mode: 5'(mode),
                             last: (i == len - 1) && (mode > 15), tl: 1'b0});
        if (mode <= 15)
            for (int i = 0; i < 6; i++)
                expq.push_back('{b: 1'b0, sec: 2'd2, mode: 5'(mode),
                                 last: (i == 5), tl: 1'b1});
        pidx     = 0;
        stall_en = stl;
        @(negedge clk);
        mode_i  = 5'(mode);
        len_i   = 12'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid) begin
            repeat (40) @(negedge clk);
            mode_i  = 5'd3;
            len_i   = 12'd100;
            start_i = 1'b1;       // R11: ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (expq.size() != 0 && n < 20000) begin
            @(posedge clk);
            n++;
        end
        check(expq.size() == 0, "R4 frame complete", expq.size(), 0);
        repeat (4) @(posedge clk);
        stall_en = 1'b0;
    endtask

    task automatic reject(input int mode, input int len, input string tag);
        @(negedge clk);
        mode_i  = 5'(mode);
        len_i   = 12'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #2;
        check(start_err_o == 1'b1, tag, int'(start_err_o), 1);
        check(out_valid_o == 1'b0, tag, int'(out_valid_o), 0);
        @(negedge clk);
        #2;
        check(start_err_o == 1'b0, tag, int'(start_err_o), 0);
        repeat (20) @(negedge clk);   // monitor flags any emitted bit
    endtask

    initial begin
        rst_n   = 1'b0;
        start_i = 1'b0;
        mode_i  = '0;
        len_i   = '0;
        for (int i = 0; i < 2152; i++) pay[i] = 1'b0;
        repeat (4) @(negedge clk);
        #2;
        check(out_valid_o == 1'b0, "R1 reset out_valid", int'(out_valid_o), 0);
        check(pl_ready_o == 1'b0, "R1 reset pl_ready", int'(pl_ready_o), 0);
        check(start_err_o == 1'b0, "R1 reset start_err", int'(start_err_o), 0);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_frame(0, 96, 1'b0, 1'b0);     // R2 R3 R4 R5 minimum length
        run_frame(16, 96, 1'b1, 1'b0);    // R5 no tail, stalled
        run_frame(20, 200, 1'b0, 1'b0);   // R5 highest repetition mode
        run_frame(15, 2152, 1'b1, 1'b0);  // R4 R9 maximum length, stalled
        run_frame(7, 500, 1'b1, 1'b1);    // R11 start mid-frame
        run_frame(21 - 8, 333, 1'b1, 1'b0);

        reject(21, 200, "R6 mode 21");
        reject(31, 200, "R6 mode 31");
        reject(3, 95, "R7 length 95");
        reject(3, 2153, "R7 length 2153");

        run_frame(11, 97, 1'b0, 1'b0);    // recovers after refusals

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule